// File: doc/BRIEF.md
# Comparator Timer Channel

This block is one comparator channel of a multi-channel event timer. A free-running main counter is shared by all channels. It reaches this channel as a value plus a tick strobe that marks each cycle in which the counter has moved. The channel holds a configuration word, a comparator and a period register that is not visible from outside. When the counter lands on the comparator value, the channel raises a single-cycle fire pulse for the interrupt router.

Software writes the channel through an external register decoder, 32 bits at a time: the configuration word, the low half of the comparator, or the high half of the comparator. In one-shot mode a comparator write arms the comparator directly. In periodic mode it loads the hidden period instead, unless a self-clearing set-value bit allows the comparator itself to be written. Each periodic match advances the comparator by the period.

A narrow mode compares only the low 32 bits and wraps all comparator arithmetic at 32 bits. If a one-shot compare value in narrow mode is already behind the counter when it is written, the channel waits for the low counter half to roll over before it can expire.

Top module: `evt_cmp_channel`

## Requirements
- R1: After reset the comparator reads all ones, the configuration readback shows only the periodic-capable flag (bit 4, so 0x10), and fire is low.
- R2: Configuration bits are: bit 1 level type (ignored, always reads 0), bit 2 channel enable, bit 3 periodic mode (writable only when periodic capability is built in), bit 4 periodic-capable (read-only), bit 6 set-value, bit 8 narrow 32-bit mode. Writing all ones reads back 0x15C.
- R3: In one-shot wide mode, a tick whose 64-bit counter equals the comparator makes fire high for exactly the following clock cycle.
- R4: No fire pulse occurs unless both the channel enable bit and the global enable input are set.
- R5: A low-half comparator write when one-shot or set-value is set replaces the comparator low half. In narrow mode it also clears the upper half.
- R6: A high-half comparator write when one-shot or set-value is set replaces the comparator upper half.
- R7: In periodic mode with set-value clear, comparator writes leave the comparator unchanged and load the period half instead. Period data has bit 31 cleared for a high-half write in any mode, and for a low-half write in narrow mode.
- R8: The set-value bit reads 0 after any comparator write, whichever half is written.
- R9: A periodic match with a nonzero period adds the period to the comparator (the sum wraps at 32 bits in narrow mode). With a zero period the comparator is left unchanged.
- R10: Writing the configuration with the narrow bit set clears the upper halves of the comparator and the period.
- R11: In narrow mode only the low 32 bits of counter and comparator are compared.
- R12: A narrow one-shot comparator write whose low half is below the counter's low half arms a wrap wait. Matches are suppressed until a tick with a zero low counter half, after which the next equal value fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en | input | 1 | Global enable of the timer block |
| cnt_tick | input | 1 | Main counter advanced this cycle; match is evaluated |
| main_cnt | input | 64 | Current main counter value |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cmp_lo_wr | input | 1 | Write strobe for the low comparator half |
| cmp_hi_wr | input | 1 | Write strobe for the high comparator half |
| wr_data | input | 32 | Write data shared by the three strobes |
| cfg_rd | output | 32 | Configuration readback |
| cmp_rd | output | 64 | Comparator readback |
| fire | output | 1 | One-cycle expiry pulse |

## Verification
The bench steers comparator writes through each routing case: one-shot, periodic with set-value, and periodic without it. It then reads the period back through the comparator value after a reload. A design that misrouted a write, or failed to clear bit 31, would show a wrong comparator after the match. Narrow mode is exercised with different upper halves on counter and comparator, with a reload sum that crosses 2^32, and with a behind-the-counter one-shot write. A design without the wrap wait would fire at the injected early match, and one that never cleared the flag would miss the real expiry after the rollover. Gating tests hold each enable low in turn while the counter sits on the comparator, so a missing gate shows up as a stray pulse.

// File: rtl/evt_chan_pkg.sv
package evt_chan_pkg;

    localparam int unsigned CFG_W   = 32;
    localparam int unsigned B_LEVEL = 1;   // level type, accepted but never stored
    localparam int unsigned B_EN    = 2;
    localparam int unsigned B_PER   = 3;
    localparam int unsigned B_PCAP  = 4;
    localparam int unsigned B_SETV  = 6;
    localparam int unsigned B_W32   = 8;

    typedef struct packed {
        logic w32;
        logic setv;
        logic per;
        logic en;
    } chan_cfg_t;

    typedef enum logic [1:0] {
        WK_NONE = 2'd0,
        WK_CFG  = 2'd1,
        WK_LO   = 2'd2,
        WK_HI   = 2'd3
    } wr_kind_t;

    function automatic wr_kind_t decode_wr(input logic c, input logic lo, input logic hi);
        if (c)       return WK_CFG;
        else if (lo) return WK_LO;
        else if (hi) return WK_HI;
        return WK_NONE;
    endfunction

    function automatic chan_cfg_t cfg_from_word(input logic [CFG_W-1:0] w, input logic cap);
        chan_cfg_t c;
        c.en   = w[B_EN];
        c.per  = w[B_PER] & cap;
        c.setv = w[B_SETV];
        c.w32  = w[B_W32];
        return c;
    endfunction

    function automatic logic [CFG_W-1:0] cfg_to_word(input chan_cfg_t c, input logic cap);
        logic [CFG_W-1:0] w;
        w         = '0;
        w[B_EN]   = c.en;
        w[B_PER]  = c.per;
        w[B_PCAP] = cap;
        w[B_SETV] = c.setv;
        w[B_W32]  = c.w32;
        return w;
    endfunction

endpackage

// File: rtl/evt_chan_cfg.sv
module evt_chan_cfg
    import evt_chan_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  wr_kind_t  wr_kind,
    input  chan_cfg_t cfg_new,
    output chan_cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else begin
            unique case (wr_kind)
                WK_CFG:       cfg_q      <= cfg_new;
                WK_LO, WK_HI: cfg_q.setv <= 1'b0;
                default:      cfg_q      <= cfg_q;
            endcase
        end
    end

    // set-value is one-shot: gone after either comparator half is written
    p_setval_selfclear_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_kind == WK_LO || wr_kind == WK_HI) |=> !cfg_q.setv);

endmodule

// File: rtl/evt_chan_value.sv
module evt_chan_value
    import evt_chan_pkg::*;
#(
    parameter int unsigned CNT_W  = 64,
    localparam int unsigned HALF_W = CNT_W / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_kind_t          wr_kind,
    input  logic [HALF_W-1:0] wr_data,
    input  chan_cfg_t         cfg_q,
    input  chan_cfg_t         cfg_new,
    input  logic [HALF_W-1:0] cnt_lo,
    input  logic              match_i,
    input  logic              rollover_i,
    output logic [CNT_W-1:0]  cmp_q,
    output logic              wrap_q
);

    logic [CNT_W-1:0]  per_q;
    logic [CNT_W-1:0]  cmp_n;
    logic [CNT_W-1:0]  per_n;
    logic              wrap_n;
    logic [HALF_W-1:0] lo_sum;
    logic [HALF_W-1:0] clamped;
    logic              direct;
    logic              arm_chk;

    assign direct  = !cfg_q.per || cfg_q.setv;
    assign lo_sum  = cmp_q[HALF_W-1:0] + per_q[HALF_W-1:0];
    assign clamped = {1'b0, wr_data[HALF_W-2:0]};
    assign arm_chk = (wr_kind == WK_LO || wr_kind == WK_HI) && cfg_q.w32 && !cfg_q.per;

    always_comb begin
        cmp_n  = cmp_q;
        per_n  = per_q;
        wrap_n = wrap_q;
        unique case (wr_kind)
            WK_CFG: begin
                if (cfg_new.w32) begin
                    cmp_n[CNT_W-1:HALF_W] = '0;
                    per_n[CNT_W-1:HALF_W] = '0;
                end
                if (!(cfg_new.w32 && !cfg_new.per)) wrap_n = 1'b0;
            end
            WK_LO: begin
                if (direct) begin
                    cmp_n[HALF_W-1:0] = wr_data;
                    if (cfg_q.w32) cmp_n[CNT_W-1:HALF_W] = '0;
                end
                if (cfg_q.per) per_n[HALF_W-1:0] = cfg_q.w32 ? clamped : wr_data;
            end
            WK_HI: begin
                if (direct) cmp_n[CNT_W-1:HALF_W] = wr_data;
                else        per_n[CNT_W-1:HALF_W] = clamped;
            end
            default: begin
                if (rollover_i) wrap_n = 1'b0;
                if (match_i && cfg_q.per) begin
                    if (cfg_q.w32) begin
                        if (per_q[HALF_W-1:0] != '0) cmp_n = {{HALF_W{1'b0}}, lo_sum};
                    end else if (per_q != '0) begin
                        cmp_n = cmp_q + per_q;
                    end
                end
            end
        endcase
        if (arm_chk) wrap_n = (cmp_n[HALF_W-1:0] < cnt_lo);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q  <= '1;
            per_q  <= '0;
            wrap_q <= 1'b0;
        end else begin
            cmp_q  <= cmp_n;
            per_q  <= per_n;
            wrap_q <= wrap_n;
        end
    end

    p_periodic_write_keeps_cmp_r7: assert property (@(posedge clk) disable iff (rst)
        ((wr_kind == WK_LO || wr_kind == WK_HI) && cfg_q.per && !cfg_q.setv) |=> $stable(cmp_q));

    p_narrow_truncates_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_kind == WK_CFG && cfg_new.w32) |=> (cmp_q[CNT_W-1:HALF_W] == '0));

    p_reload_moves_cmp_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_kind == WK_NONE && match_i && cfg_q.per && !cfg_q.w32 && per_q != '0)
        |=> (cmp_q != $past(cmp_q)));

endmodule

// File: rtl/evt_chan_match.sv
module evt_chan_match #(
    parameter int unsigned CNT_W  = 64,
    localparam int unsigned HALF_W = CNT_W / 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             glb_en,
    input  logic             ch_en,
    input  logic             w32,
    input  logic             wrap_q,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cmp_q,
    output logic             match_o,
    output logic             rollover_o,
    output logic             fire_o
);

    logic live;
    logic eq;
    logic lo_zero;

    assign live    = tick && glb_en;
    assign lo_zero = (cnt_i[HALF_W-1:0] == '0);
    assign eq      = w32 ? (cnt_i[HALF_W-1:0] == cmp_q[HALF_W-1:0]) : (cnt_i == cmp_q);

    assign match_o    = live && eq && (!wrap_q || lo_zero);
    assign rollover_o = live && wrap_q && lo_zero;

    always_ff @(posedge clk) begin
        if (rst) fire_o <= 1'b0;
        else     fire_o <= match_o && ch_en;
    end

    p_fire_needs_enables_r4: assert property (@(posedge clk) disable iff (rst)
        fire_o |-> ($past(glb_en) && $past(ch_en)));

    p_fire_needs_tick_r3: assert property (@(posedge clk) disable iff (rst)
        fire_o |-> $past(tick));

    p_wrap_blocks_fire_r12: assert property (@(posedge clk) disable iff (rst)
        (live && wrap_q && !lo_zero) |=> !fire_o);

endmodule

// File: rtl/evt_cmp_channel.sv
module evt_cmp_channel
    import evt_chan_pkg::*;
#(
    parameter int unsigned CNT_W        = 64,
    parameter bit          PERIODIC_CAP = 1'b1,
    localparam int unsigned HALF_W      = CNT_W / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              glb_en,
    input  logic              cnt_tick,
    input  logic [CNT_W-1:0]  main_cnt,
    input  logic              cfg_wr,
    input  logic              cmp_lo_wr,
    input  logic              cmp_hi_wr,
    input  logic [HALF_W-1:0] wr_data,
    output logic [CFG_W-1:0]  cfg_rd,
    output logic [CNT_W-1:0]  cmp_rd,
    output logic              fire
);

    wr_kind_t  wr_kind;
    chan_cfg_t cfg_new;
    chan_cfg_t cfg_q;
    logic      match;
    logic      rollover;
    logic      wrap_q;

    assign wr_kind = decode_wr(cfg_wr, cmp_lo_wr, cmp_hi_wr);
    assign cfg_new = cfg_from_word(CFG_W'(wr_data), PERIODIC_CAP);
    assign cfg_rd  = cfg_to_word(cfg_q, PERIODIC_CAP);

    evt_chan_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_kind (wr_kind),
        .cfg_new (cfg_new),
        .cfg_q   (cfg_q)
    );

    evt_chan_value #(.CNT_W(CNT_W)) u_value (
        .clk        (clk),
        .rst        (rst),
        .wr_kind    (wr_kind),
        .wr_data    (wr_data),
        .cfg_q      (cfg_q),
        .cfg_new    (cfg_new),
        .cnt_lo     (main_cnt[HALF_W-1:0]),
        .match_i    (match),
        .rollover_i (rollover),
        .cmp_q      (cmp_rd),
        .wrap_q     (wrap_q)
    );

    evt_chan_match #(.CNT_W(CNT_W)) u_match (
        .clk        (clk),
        .rst        (rst),
        .tick       (cnt_tick),
        .glb_en     (glb_en),
        .ch_en      (cfg_q.en),
        .w32        (cfg_q.w32),
        .wrap_q     (wrap_q),
        .cnt_i      (main_cnt),
        .cmp_q      (cmp_rd),
        .match_o    (match),
        .rollover_o (rollover),
        .fire_o     (fire)
    );

    // the decoder presents at most one write per cycle
    p_single_write_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cfg_wr, cmp_lo_wr, cmp_hi_wr}));

endmodule

// File: tb/evt_cmp_channel_bench.sv
`timescale 1ns/1ps
module evt_cmp_channel_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        glb_en;
    logic        cnt_tick;
    logic [63:0] main_cnt;
    logic        cfg_wr;
    logic        cmp_lo_wr;
    logic        cmp_hi_wr;
    logic [31:0] wr_data;
    logic [31:0] cfg_rd;
    logic [63:0] cmp_rd;
    logic        fire;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    evt_cmp_channel u_evt_cmp_channel (
        .clk       (clk),
        .rst       (rst),
        .glb_en    (glb_en),
        .cnt_tick  (cnt_tick),
        .main_cnt  (main_cnt),
        .cfg_wr    (cfg_wr),
        .cmp_lo_wr (cmp_lo_wr),
        .cmp_hi_wr (cmp_hi_wr),
        .wr_data   (wr_data),
        .cfg_rd    (cfg_rd),
        .cmp_rd    (cmp_rd),
        .fire      (fire)
    );

    typedef struct packed {
        logic [63:0] cmp;
        logic        w32;
        logic [63:0] cnt;
        logic        exp;
    } vec_t;

    localparam vec_t VECS [0:7] = '{
        '{64'h0000_0001_0000_0010, 1'b0, 64'h0000_0001_0000_0010, 1'b1},
        '{64'h0000_0001_0000_0010, 1'b0, 64'h0000_0000_0000_0010, 1'b0},
        '{64'h0000_0001_0000_0010, 1'b1, 64'h0000_0005_0000_0010, 1'b1},
        '{64'h0000_0000_0000_0020, 1'b1, 64'h0000_0000_0000_0021, 1'b0},
        '{64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1},
        '{64'h0000_0000_0000_0000, 1'b0, 64'h0000_0000_0000_0000, 1'b1},
        '{64'hDEAD_BEEF_0000_0000, 1'b0, 64'hDEAD_BEEE_0000_0000, 1'b0},
        '{64'hABCD_0000_8000_0000, 1'b1, 64'h1234_5678_8000_0000, 1'b1}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; glb_en = 1'b1; cnt_tick = 1'b0; main_cnt = '0;
        cfg_wr = 1'b0; cmp_lo_wr = 1'b0; cmp_hi_wr = 1'b0; wr_data = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr_cfg(input logic [31:0] v);
        @(negedge clk); cfg_wr = 1'b1; wr_data = v;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic wr_lo(input logic [31:0] v);
        @(negedge clk); cmp_lo_wr = 1'b1; wr_data = v;
        @(negedge clk); cmp_lo_wr = 1'b0;
    endtask

    task automatic wr_hi(input logic [31:0] v);
        @(negedge clk); cmp_hi_wr = 1'b1; wr_data = v;
        @(negedge clk); cmp_hi_wr = 1'b0;
    endtask

    // one counter tick; fire is sampled in the cycle after the tick edge
    task automatic tick(input logic [63:0] c, input logic exp, input string tag);
        @(negedge clk); main_cnt = c; cnt_tick = 1'b1;
        @(negedge clk); cnt_tick = 1'b0;
        check(tag, {63'b0, fire}, {63'b0, exp});
        @(negedge clk);
        check("R3 pulse lasts one cycle", {63'b0, fire}, 64'd0);
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        check("R1 cmp after reset", cmp_rd, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R1 cfg after reset", {32'b0, cfg_rd}, 64'h10);
        check("R1 fire after reset", {63'b0, fire}, 64'd0);

        // R2 writable bits, level bit ignored
        wr_cfg(32'hFFFF_FFFF);
        check("R2 cfg readback", {32'b0, cfg_rd}, 64'h15C);

        // R3 / R11 vector table: one-shot compares
        for (int i = 0; i < 8; i++) begin
            do_reset();
            wr_cfg(VECS[i].w32 ? 32'h104 : 32'h4);
            wr_lo(VECS[i].cmp[31:0]);
            wr_hi(VECS[i].cmp[63:32]);
            tick(VECS[i].cnt, VECS[i].exp, VECS[i].w32 ? "R11 narrow compare" : "R3 wide compare");
        end

        // R4 gating
        do_reset();
        wr_cfg(32'h0);
        wr_lo(32'h50);
        wr_hi(32'h0);
        tick(64'h50, 1'b0, "R4 channel disabled");
        wr_cfg(32'h4);
        glb_en = 1'b0;
        tick(64'h50, 1'b0, "R4 global disabled");
        glb_en = 1'b1;
        tick(64'h50, 1'b1, "R4 both enabled");

        // R5 R6 R10 direct writes and narrowing
        do_reset();
        wr_cfg(32'h4);
        wr_hi(32'h1234_5678);
        check("R6 high half write", cmp_rd, 64'h1234_5678_FFFF_FFFF);
        wr_cfg(32'h104);
        check("R10 narrow truncates", cmp_rd, 64'h0000_0000_FFFF_FFFF);
        wr_hi(32'hAAAA_0000);
        wr_lo(32'h55);
        check("R5 narrow low write clears upper", cmp_rd, 64'h55);

        // R7 R8 R9 wide periodic
        do_reset();
        wr_cfg(32'h4C);
        wr_hi(32'h0);
        check("R8 setval cleared by high write", {32'b0, cfg_rd}, 64'h1C);
        wr_cfg(32'h4C);
        wr_lo(32'h100);
        check("R8 setval cleared by low write", {32'b0, cfg_rd}, 64'h1C);
        check("R5 setval low write", cmp_rd, 64'h100);
        tick(64'h100, 1'b1, "R9 periodic fire");
        check("R9 reload by period", cmp_rd, 64'h200);
        wr_hi(32'hFFFF_FFFF);
        check("R7 periodic write keeps cmp", cmp_rd, 64'h200);
        tick(64'h200, 1'b1, "R9 periodic fire 2");
        check("R7 clamped high period", cmp_rd, 64'h7FFF_FFFF_0000_0300);

        // R7 R9 narrow periodic wrap
        do_reset();
        wr_cfg(32'h14C);
        wr_lo(32'hFFFF_FFF0);
        wr_lo(32'h8000_0020);
        check("R7 narrow periodic write keeps cmp", cmp_rd, 64'hFFFF_FFF0);
        tick(64'h0000_0003_FFFF_FFF0, 1'b1, "R9 narrow periodic fire");
        check("R9 narrow reload wraps", cmp_rd, 64'h10);

        // R9 zero period
        do_reset();
        wr_cfg(32'h4C);
        wr_hi(32'h0);
        wr_cfg(32'h4C);
        wr_lo(32'h30);
        wr_lo(32'h0);
        tick(64'h30, 1'b1, "R9 zero period fire");
        check("R9 zero period keeps cmp", cmp_rd, 64'h30);

        // R12 wrap wait
        do_reset();
        main_cnt = 64'h1000;
        wr_cfg(32'h104);
        wr_lo(32'h800);
        tick(64'h800, 1'b0, "R12 early match suppressed");
        tick(64'h0000_0000_FFFF_FFFF, 1'b0, "R12 before rollover");
        tick(64'h0000_0001_0000_0000, 1'b0, "R12 rollover no fire");
        tick(64'h0000_0001_0000_0800, 1'b1, "R12 real expiry");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule